// File: doc/BRIEF.md
# Steering Phase-Frequency Detector

This block compares a feedback event stream with a reference event stream and produces a three-level drive code and a lock flag. It is meant for a digital control loop. Both inputs arrive already squared and synchronised to the system clock. A ten-state sequence machine advances on input events. A feedback event turns it one way and a reference event turns it the other.

While one input runs faster than the other, the machine holds the drive at full strength in the direction that corrects the error. This shortens acquisition. Once the two rates match, the drive becomes a pulse whose width is the time between the two edges. For the rest of each period the drive sits at the high-impedance mid level. An active-low control makes both edges of the feedback input count, which doubles the effective feedback rate.

The lock flag is high whenever the machine is in a phase-only state. It drops while a frequency error is being tracked.

Top module: `pfd_steer_top`

## Requirements
- R1: After a synchronous active-low reset the drive code is mid (2'b00) and `in_lock` is 1.
- R2: Falling edges of `ref_in` never change the outputs. Falling edges of `fb_in` change nothing while `dual_edge_n` is 1.
- R3: The drive code is 2'b00 for mid, 2'b01 for high drive and 2'b10 for low drive. An input event shows at the outputs one clock after the cycle in which the new input level is first present.
- R4: With a feedback lead, a feedback rising edge turns the drive high. The next reference rising edge returns it to mid.
- R5: With a feedback lag, a reference rising edge turns the drive low. The next feedback rising edge returns it to mid.
- R6: A second feedback event arriving before the reference catches up pins the drive high and clears `in_lock`. Both stay that way through one reference event. A further reference event moves the machine to a transitional state: drive mid, `in_lock` still 0.
- R7: The same holds mirrored for the reference. A second reference event pins the drive low and clears `in_lock`. Both stay that way through one feedback event, and a further feedback event gives the transitional state: drive mid, `in_lock` 0.
- R8: From either transitional state, a feedback event gives drive high with `in_lock` 1.
- R9: `in_lock` is 1 exactly in the four phase-only states and 0 in the six frequency-error and transitional states.
- R10: When `dual_edge_n` is 0, a falling edge of `fb_in` counts as a feedback event.
- R11: A feedback event and a reference event in the same clock cycle cancel each other, and the outputs do not change.
- R12: Further feedback events in the deepest positive frequency-error state keep the drive high and `in_lock` 0. Further reference events in the deepest negative state keep the drive low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_in | input | 1 | Feedback stream, synchronised |
| ref_in | input | 1 | Reference stream, synchronised |
| dual_edge_n | input | 1 | Low: both feedback edges count |
| drive_code | output | 2 | 00 mid, 01 high drive, 10 low drive |
| in_lock | output | 1 | High in phase-only states |

## Verification
A wrong state shows up at the ports one clock after the event that caused it. It can appear as a drive code of the wrong polarity, as a mid level where full drive was due, or as `in_lock` disagreeing with the frequency-error condition. Some states share an output, such as the two high frequency-error states or the two phase-only mid states. A mistake between such states stays hidden until the next event, which then leads out of the wrong state. The directed sequences therefore chain several events and check the outputs after each one.

// File: rtl/pfd_pkg.sv
// Shared types for the steering phase-frequency detector.
// Assumes the state is encoded in four bits with the state number as its value.
package pfd_pkg;
    localparam int ST_W  = 4;
    localparam int LVL_W = 2;

    typedef enum logic [ST_W-1:0] {
        S1  = 4'd1,  S2 = 4'd2, S3 = 4'd3, S4 = 4'd4, S5 = 4'd5,
        S6  = 4'd6,  S7 = 4'd7, S8 = 4'd8, S9 = 4'd9, S10 = 4'd10
    } pfd_state_t;

    typedef enum logic [LVL_W-1:0] {
        LVL_MID  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_LOW  = 2'b10
    } pfd_level_t;
endpackage

// File: rtl/pfd_edge_sense.sv
// Turns a synchronised level into a one-cycle event pulse.
// Detects rising edges, or any change when both_en is set.
// Assumes sig is already synchronous to clk.
module pfd_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic both_en,
    output logic ev
);
    logic prev_q;

    // hold the previous sample of the input level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // pick rising-only or both-edge detection
    always_comb begin
        if (both_en) ev = sig ^ prev_q;
        else         ev = sig & ~prev_q;
    end
endmodule

// File: rtl/pfd_seq_fsm.sv
// Ten-state sequence machine. Feedback events step it one way and
// reference events step it the other. Simultaneous events cancel.
// Assumes the event inputs are single-cycle pulses.
module pfd_seq_fsm
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fb_ev,
    input  logic       ref_ev,
    output pfd_state_t state
);
    pfd_state_t nxt;
    logic fb_only, ref_only;

    // isolate unopposed events
    always_comb begin
        fb_only  = fb_ev & ~ref_ev;
        ref_only = ref_ev & ~fb_ev;
    end

    // next-state selection per event
    always_comb begin
        nxt = state;
        if (fb_only) begin
            unique case (state)
                S2:      nxt = S1;
                S3:      nxt = S4;
                S4:      nxt = S5;
                S7, S8:  nxt = S8;
                S9:      nxt = S8;
                default: nxt = S7;
            endcase
        end else if (ref_only) begin
            unique case (state)
                S2, S3:  nxt = S3;
                S4:      nxt = S3;
                S7:      nxt = S6;
                S8:      nxt = S9;
                S9:      nxt = S10;
                default: nxt = S2;
            endcase
        end
    end

    // state register, reset to a phase-only mid state
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S6;
        else        state <= nxt;
    end

    // R11
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_ev && ref_ev) |=> $stable(state));

    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S8 && fb_ev && !ref_ev) |=> (state == S8));

    // R9
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state >= S1) && (state <= S10));
endmodule

// File: rtl/pfd_level_map.sv
// Decodes the state number into drive code and lock flag.
// Assumes the state is one of the ten legal codes.
module pfd_level_map
    import pfd_pkg::*;
(
    input  pfd_state_t state,
    output pfd_level_t level,
    output logic       lock_ok
);
    // state to drive level and lock flag
    always_comb begin
        unique case (state)
            S7, S8, S9: level = LVL_HIGH;
            S2, S3, S4: level = LVL_LOW;
            default:    level = LVL_MID;
        endcase
        lock_ok = (state == S1) || (state == S2) ||
                  (state == S6) || (state == S7);
    end
endmodule

// File: rtl/pfd_steer_top.sv
// Top of the steering phase-frequency detector: edge sensing on both
// inputs, the sequence machine and the output decode.
// Assumes fb_in and ref_in are synchronised to clk.
module pfd_steer_top
    import pfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fb_in,
    input  logic             ref_in,
    input  logic             dual_edge_n,
    output logic [LVL_W-1:0] drive_code,
    output logic             in_lock
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_lvl, both_sel, ev;
    pfd_state_t     state;
    pfd_level_t     level;

    // channel 0 is feedback, channel 1 is reference (rising only)
    always_comb begin
        raw_lvl  = {ref_in, fb_in};
        both_sel = {1'b0, ~dual_edge_n};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
        pfd_edge_sense u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig    (raw_lvl[ch]),
            .both_en(both_sel[ch]),
            .ev     (ev[ch])
        );
    end

    pfd_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .fb_ev (ev[0]),
        .ref_ev(ev[1]),
        .state (state)
    );

    pfd_level_map u_map (
        .state  (state),
        .level  (level),
        .lock_ok(in_lock)
    );

    // drive port from the decoded level
    always_comb drive_code = level;

    // R4
    high_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_code == LVL_HIGH && $past(drive_code) != LVL_HIGH) |-> $past(ev[0]));

    // R5
    low_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_code == LVL_LOW && $past(drive_code) != LVL_LOW) |-> $past(ev[1]));

    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0) |=> ($stable(drive_code) && $stable(in_lock)));
endmodule

// File: tb/pfd_steer_top_test.sv
module pfd_steer_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_in = 1'b0;
    logic ref_in = 1'b0;
    logic dual_edge_n = 1'b1;
    logic [1:0] drive_code;
    logic in_lock;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [1:0] MID = 2'b00, HIGH = 2'b01, LOW = 2'b10;

    always #4 clk = ~clk;

    pfd_steer_top uut (
        .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .ref_in(ref_in),
        .dual_edge_n(dual_edge_n), .drive_code(drive_code), .in_lock(in_lock)
    );

    task automatic chk(input string tag, input logic [1:0] ed, input logic el);
        n_run++;
        if (drive_code !== ed || in_lock !== el) begin
            n_fail++;
            $display("FAIL %s: drive=%b lock=%b expected drive=%b lock=%b",
                     tag, drive_code, in_lock, ed, el);
        end
    endtask

    task automatic tick(input logic f, input logic r);
        @(negedge clk);
        fb_in = f;
        ref_in = r;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fb_in = 1'b0; ref_in = 1'b0; dual_edge_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1; chk("R1 reset", MID, 1'b1);
    endtask

    task automatic t_lead();
        do_reset();
        tick(1, 0); chk("R4 fb edge high", HIGH, 1'b1);
        tick(0, 0); chk("R4 held high", HIGH, 1'b1);
        tick(0, 1); chk("R4 ref edge mid", MID, 1'b1);
        tick(0, 0); chk("R3 mid hold", MID, 1'b1);
    endtask

    task automatic t_lag();
        do_reset();
        tick(0, 1); chk("R5 ref edge low", LOW, 1'b1);
        tick(0, 0); chk("R2 ref fall ignored", LOW, 1'b1);
        tick(1, 0); chk("R5 fb edge mid", MID, 1'b1);
    endtask

    task automatic t_pos_freq();
        do_reset();
        tick(1, 0); tick(0, 0);
        tick(1, 0); chk("R6 pinned high", HIGH, 1'b0);
        tick(0, 1); chk("R6 one ref absorbed", HIGH, 1'b0);
        tick(0, 0);
        tick(0, 1); chk("R6 transitional", MID, 1'b0);
        tick(1, 0); chk("R8 exit to high phase", HIGH, 1'b1);
        tick(0, 0);
        tick(1, 0); chk("R6 re-enter freq", HIGH, 1'b0);
        tick(0, 0);
        tick(1, 0); chk("R12 saturated high", HIGH, 1'b0);
        tick(0, 1); chk("R12 one ref after saturation", HIGH, 1'b0);
    endtask

    task automatic t_neg_freq();
        do_reset();
        tick(0, 1); tick(0, 0);
        tick(0, 1); chk("R7 pinned low", LOW, 1'b0);
        tick(0, 0);
        tick(0, 1); chk("R12 saturated low", LOW, 1'b0);
        tick(1, 0); chk("R7 one fb absorbed", LOW, 1'b0);
        tick(0, 0);
        tick(1, 0); chk("R7 transitional", MID, 1'b0);
        tick(0, 0); chk("R9 transitional lock low", MID, 1'b0);
        tick(1, 0); chk("R8 exit to high phase", HIGH, 1'b1);
    endtask

    task automatic t_cancel();
        do_reset();
        tick(1, 1); chk("R11 cancel at mid", MID, 1'b1);
        tick(0, 0);
        tick(1, 0); chk("R4 setup high", HIGH, 1'b1);
        tick(0, 0);
        tick(1, 1); chk("R11 cancel at high", HIGH, 1'b1);
    endtask

    task automatic t_dual();
        do_reset();
        dual_edge_n = 1'b0;
        tick(1, 0); chk("R10 rise counts", HIGH, 1'b1);
        tick(0, 0); chk("R10 fall counts", HIGH, 1'b0);
        do_reset();
        tick(1, 0); tick(0, 0); chk("R2 fb fall ignored", HIGH, 1'b1);
        tick(0, 1); tick(0, 0); chk("R2 ref fall ignored", MID, 1'b1);
    endtask

    initial begin
        t_reset();
        t_lead();
        t_lag();
        t_pos_freq();
        t_neg_freq();
        t_cancel();
        t_dual();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule